// File: doc/BRIEF.md
# Integrating Fault Input Filter

This block decides whether an external fault or brake line is really asserted before a shutdown path is allowed to act on it. The raw line is first synchronized to the system clock. It is then sampled at a programmable fraction of that clock. Each sample moves an up/down integrating counter: one step up when the line is at its active level, one step down when it is not. The counter saturates at zero and at a programmable trip threshold. When it reaches the threshold, a sticky fault flag is raised. The flag stays raised until software clears it or the filter is disabled.

Short glitches only nudge the counter up a little, and it decays again once the line returns to its idle level. A sustained fault climbs all the way to the threshold. The rate select and the threshold select together set the confirmation time. That time ranges from 16 clock cycles (divide by 4, 4 samples) to 16384 clock cycles (divide by 128, 128 samples). An optional low-level mode makes a low line count as the fault condition instead of a high one. Two status outputs report whether the counter holds a non-zero value and the direction of its latest step.

Top module: `fault_integ_filter`

## Requirements
- R1: After reset, `cnt_active`, `cnt_up`, `fault_flag` and `lvl_mode` are all 0.
- R2: `fault_in` passes through two clock-edge registers before it is sampled. A change applied just before edge k is first seen by a sample taken at edge k+2 or later.
- R3: `rate_sel` sets the sample period in enabled clock cycles: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 128. The first sample falls on the period-th rising edge after `enable` goes high.
- R4: `cmp_sel` sets the trip threshold: 0 gives 4, 1 gives 16, 2 gives 64, 3 gives 128. `fault_flag` rises at the clock edge where a sample brings the counter to the threshold. For example, with both selects at 0 and the input held active, it rises on the 16th edge after enabling.
- R5: At each sample, the counter is first clamped to the threshold. It then steps up by one when the synchronized input is at its active level, or down by one when it is not, saturating at 0 and at the threshold. Between samples it holds.
- R6: `cnt_active` is 1 exactly when the counter is non-zero.
- R7: `cnt_up` holds 1 if the latest sample saw the active level and 0 otherwise. It is 0 after reset and while disabled.
- R8: `fault_flag` is sticky. Only a `flag_clr` pulse or deasserting `enable` clears it. `flag_clr` wins over a set in the same cycle.
- R9: While `enable` is 0, the counter, the prescaler, `cnt_up` and `fault_flag` are held at 0, and `fault_in` has no effect on them.
- R10: A `lvl_set` pulse sets `lvl_mode` and a `lvl_clr` pulse clears it, with clear winning. While `lvl_mode` is 1, a low `fault_in` is the active level. While it is 0, a high `fault_in` is the active level.
- R11: Changing `rate_sel` or `cmp_sel` while enabled does not reset the counter. The new values apply from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 1 | Raw external fault/brake line |
| enable | input | 1 | Filter enable; 0 clears counter, prescaler and flag |
| rate_sel | input | 2 | Sample period select |
| cmp_sel | input | 2 | Trip threshold select |
| lvl_set | input | 1 | Pulse: enable low-level detection |
| lvl_clr | input | 1 | Pulse: disable low-level detection |
| flag_clr | input | 1 | Pulse: clear the confirmed-fault flag |
| cnt_active | output | 1 | Counter is non-zero |
| cnt_up | output | 1 | Direction of the latest counter step |
| fault_flag | output | 1 | Sticky confirmed fault |
| lvl_mode | output | 1 | Low-level detection is active |

## Verification
Directed cases check exact edges for four behaviours: the fastest trip time, the two-edge synchronizer delay just before a sample, the decay of the counter under a released input while the flag holds, and low-level tripping. A held-active input separates the trip thresholds and sample periods. A held-inactive input shows that the counter floors at zero and that direction reports down. Random glitch trains with varied density separate true integration from simple debounce, because a brief return to idle only steps the counter back by one. Mid-run select changes, clear pulses, disable pulses and level-mode toggles are compared cycle by cycle against a reference model in the bench.

// File: rtl/fif_pkg.sv
package fif_pkg;

    typedef enum logic [1:0] {
        RATE_A = 2'd0,
        RATE_B = 2'd1,
        RATE_C = 2'd2,
        RATE_D = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        THR_A = 2'd0,
        THR_B = 2'd1,
        THR_C = 2'd2,
        THR_D = 2'd3
    } thr_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fif_sync.sv
module fif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/fif_prescaler.sv
module fif_prescaler
    import fif_pkg::*;
#(
    parameter int unsigned DIV0 = 4,
    parameter int unsigned DIV1 = 8,
    parameter int unsigned DIV2 = 16,
    parameter int unsigned DIV3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int unsigned DIV_MAX = max4(DIV0, DIV1, DIV2, DIV3);
    localparam int PRE_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        case (rate_sel)
            RATE_A:  last = PRE_W'(DIV0 - 1);
            RATE_B:  last = PRE_W'(DIV1 - 1);
            RATE_C:  last = PRE_W'(DIV2 - 1);
            default: last = PRE_W'(DIV3 - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!en) begin
            st_d.pre = '0;
        end else if (st_q.pre >= last) begin
            tick     = 1'b1;
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R3
    AST_NO_TICK_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);  // R9
endmodule

// File: rtl/fif_integrator.sv
module fif_integrator
    import fif_pkg::*;
#(
    parameter int unsigned THR0 = 4,
    parameter int unsigned THR1 = 16,
    parameter int unsigned THR2 = 64,
    parameter int unsigned THR3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       level,
    input  logic [1:0] cmp_sel,
    input  logic       flag_clr,
    output logic       cnt_nz,
    output logic       dir,
    output logic       fault
);
    localparam int unsigned THR_MAX = max4(THR0, THR1, THR2, THR3);
    localparam int CNT_W = $clog2(THR_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             fault;
    } int_st_t;

    int_st_t          st_d, st_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        case (cmp_sel)
            THR_A:   thr = CNT_W'(THR0);
            THR_B:   thr = CNT_W'(THR1);
            THR_C:   thr = CNT_W'(THR2);
            default: thr = CNT_W'(THR3);
        endcase
    end

    always_comb begin
        base = (st_q.cnt > thr) ? thr : st_q.cnt;
        if (level) nxt = (base == thr) ? thr : base + 1'b1;
        else       nxt = (base == '0) ? '0 : base - 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            if (tick) begin
                st_d.cnt = nxt;
                st_d.dir = level;
            end
            if (flag_clr)                st_d.fault = 1'b0;
            else if (tick && nxt == thr) st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_nz = (st_q.cnt != '0);
    assign dir    = st_q.dir;
    assign fault  = st_q.fault;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (st_q.cnt <= $past(thr)));  // R5
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.cnt));  // R5
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0 && !st_q.fault && !st_q.dir));  // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.fault && !flag_clr) |=> st_q.fault);  // R8
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !st_q.fault);  // R8
endmodule

// File: rtl/fault_integ_filter.sv
module fault_integ_filter #(
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned DIV0 = 4,
    parameter int unsigned DIV1 = 8,
    parameter int unsigned DIV2 = 16,
    parameter int unsigned DIV3 = 128,
    parameter int unsigned THR0 = 4,
    parameter int unsigned THR1 = 16,
    parameter int unsigned THR2 = 64,
    parameter int unsigned THR3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_in,
    input  logic       enable,
    input  logic [1:0] rate_sel,
    input  logic [1:0] cmp_sel,
    input  logic       lvl_set,
    input  logic       lvl_clr,
    input  logic       flag_clr,
    output logic       cnt_active,
    output logic       cnt_up,
    output logic       fault_flag,
    output logic       lvl_mode
);
    typedef struct packed {
        logic low;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    fault_s;
    logic    level;
    logic    tick;

    always_comb begin
        st_d = st_q;
        if (lvl_clr)      st_d.low = 1'b0;
        else if (lvl_set) st_d.low = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.low ? ~fault_s : fault_s;
    assign lvl_mode = st_q.low;

    fif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (fault_in),
        .dout (fault_s)
    );

    fif_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .rate_sel(rate_sel),
        .tick    (tick)
    );

    fif_integrator #(.THR0(THR0), .THR1(THR1), .THR2(THR2), .THR3(THR3)) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .tick    (tick),
        .level   (level),
        .cmp_sel (cmp_sel),
        .flag_clr(flag_clr),
        .cnt_nz  (cnt_active),
        .dir     (cnt_up),
        .fault   (fault_flag)
    );

    AST_LVL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_clr |=> !lvl_mode);  // R10
    AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_set && !lvl_clr) |=> lvl_mode);  // R10
endmodule

// File: tb/fault_integ_filter_tb_top.sv
`timescale 1ns/100ps
module fault_integ_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_in = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [1:0] cmp_sel = 2'd0;
    logic       lvl_set = 1'b0;
    logic       lvl_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cnt_active, cnt_up, fault_flag, lvl_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fault_integ_filter dut_i (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .enable(enable),
        .rate_sel(rate_sel), .cmp_sel(cmp_sel), .lvl_set(lvl_set),
        .lvl_clr(lvl_clr), .flag_clr(flag_clr), .cnt_active(cnt_active),
        .cnt_up(cnt_up), .fault_flag(fault_flag), .lvl_mode(lvl_mode)
    );

    // Expected-value helpers taken from the requirement encodings (R3, R4)
    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 16;
            default: return 128;
        endcase
    endfunction

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 16;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at every rising edge
    bit m_s1, m_s2, m_low, m_dir, m_fault, m_tick;
    int m_pre, m_cnt;

    always @(posedge clk) begin
        bit lvl;
        int b;
        int nx;
        int t;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_low = 0; m_dir = 0; m_fault = 0;
            m_pre = 0; m_cnt = 0;
        end else begin
            lvl = m_low ? !m_s2 : m_s2;           // R10 active level
            t = thr_of(cmp_sel);
            if (!enable) begin                    // R9
                m_pre = 0; m_cnt = 0; m_dir = 0; m_fault = 0;
            end else begin
                m_tick = (m_pre >= period_of(rate_sel) - 1);   // R3, R11
                m_pre = m_tick ? 0 : m_pre + 1;
                b = (m_cnt > t) ? t : m_cnt;                   // R5
                if (lvl) nx = (b == t) ? t : b + 1;
                else     nx = (b == 0) ? 0 : b - 1;
                if (m_tick) begin
                    m_cnt = nx;
                    m_dir = lvl;
                end
                if (flag_clr)               m_fault = 0;       // R8
                else if (m_tick && nx == t) m_fault = 1;       // R4
            end
            m_s2 = m_s1;                          // R2
            m_s1 = fault_in;
            if (lvl_clr)      m_low = 0;
            else if (lvl_set) m_low = 1;
        end
    end

    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(fault_flag == m_fault, "R3/R4/R5/R11 fault_flag", fault_flag, m_fault);
            check(cnt_active == (m_cnt != 0), "R6 cnt_active", cnt_active, m_cnt != 0);
            check(cnt_up == m_dir, "R7 cnt_up", cnt_up, m_dir);
            check(lvl_mode == m_low, "R10 lvl_mode", lvl_mode, m_low);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1; @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        check(cnt_active == 0 && cnt_up == 0 && fault_flag == 0 && lvl_mode == 0,
              "R1 reset outputs", {cnt_active, cnt_up, fault_flag, lvl_mode}, 0);
        rst_n = 1;
        model_on = 1;
        cyc(1);
        check(fault_flag == 0 && lvl_mode == 0, "R1 after release",
              {fault_flag, lvl_mode}, 0);

        // R9: disabled filter ignores an active input
        fault_in = 1;
        cyc(20);
        check(cnt_active == 0, "R9 disabled cnt_active", cnt_active, 0);
        check(fault_flag == 0, "R9 disabled fault_flag", fault_flag, 0);

        // R4: fastest trip lands exactly on the 16th edge
        enable = 1;
        cyc(15);
        check(fault_flag == 0, "R4 no trip at edge 15", fault_flag, 0);
        check(cnt_active == 1 && cnt_up == 1, "R6 R7 climbing", {cnt_active, cnt_up}, 3);
        cyc(1);
        check(fault_flag == 1, "R4 trip at edge 16", fault_flag, 1);

        // R8: flag holds while counter decays, then clears on pulse
        fault_in = 0;
        cyc(40);
        check(fault_flag == 1, "R8 flag sticky", fault_flag, 1);
        check(cnt_active == 0, "R5 floor at zero", cnt_active, 0);
        check(cnt_up == 0, "R7 counting down", cnt_up, 0);
        pulse_clr();
        check(fault_flag == 0, "R8 cleared by pulse", fault_flag, 0);

        // R2: input raised just before edge E2 is not seen by the sample at E3
        enable = 0;
        cyc(4);
        enable = 1;
        cyc(2);
        fault_in = 1;
        cyc(2);
        check(cnt_active == 0, "R2 sync delay before sample", cnt_active, 0);
        cyc(4);
        check(cnt_active == 1, "R2 seen at next sample", cnt_active, 1);

        // R10: low level trips in low-level mode
        enable = 0;
        fault_in = 0;
        lvl_set = 1; cyc(1); lvl_set = 0;
        check(lvl_mode == 1, "R10 set", lvl_mode, 1);
        cyc(3);
        enable = 1;
        cyc(16);
        check(fault_flag == 1, "R10 low-level trip", fault_flag, 1);
        lvl_set = 1; lvl_clr = 1; cyc(1); lvl_set = 0; lvl_clr = 0;
        check(lvl_mode == 0, "R10 clear wins", lvl_mode, 0);
        enable = 0; cyc(1);
        check(fault_flag == 0, "R9 disable clears flag", fault_flag, 0);

        // Random segments with mid-run select changes (R11)
        for (int seg = 0; seg < 60; seg++) begin
            int pat;
            int len;
            int dens;
            pat  = $urandom_range(0, 3);
            rate_sel = 2'($urandom_range(0, 3));
            cmp_sel  = 2'($urandom_range(0, 3));
            if (rate_sel == 2'd3 && cmp_sel == 2'd3) len = 17000;
            else len = $urandom_range(200, 2500);
            dens = $urandom_range(10, 90);
            if ($urandom_range(0, 3) == 0) begin lvl_set = 1; cyc(1); lvl_set = 0; end
            if ($urandom_range(0, 3) == 0) begin lvl_clr = 1; cyc(1); lvl_clr = 0; end
            enable = 1;
            for (int i = 0; i < len; i++) begin
                case (pat)
                    0: fault_in = 1;
                    1: fault_in = 0;
                    2: fault_in = ($urandom_range(0, 99) < dens);
                    default: fault_in = ((i / 37) % 3 != 0);
                endcase
                flag_clr = ($urandom_range(0, 299) == 0);
                if ($urandom_range(0, 999) == 0) begin
                    rate_sel = 2'($urandom_range(0, 2));
                    cmp_sel  = 2'($urandom_range(0, 3));
                end
                enable = ($urandom_range(0, 1999) != 0);
                cyc(1);
            end
            flag_clr = 0;
        end
        done = 1;
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule